// File: doc/BRIEF.md
# Flip-Flop Register File with Gated-OR Read Ports

This block is a general-purpose register file for a processor pipeline: 32 entries of 32 bits, stored in individual flip-flops, with one clocked write port and two combinational read ports. Each read port decodes its address into a one-hot select vector. Every stored word is masked by its own select bit, and a wide OR of all the masked words gives the read result. The design uses this AND-OR tree in place of a multiplexer.

Entry zero is the hard-wired zero register. No read port checks for address zero. Instead, the write decoder never produces a strobe for entry zero, and reset clears it. The zero therefore comes from the stored contents, and the read path has no extra compare. Writes aimed at address zero are allowed and simply have no effect.

Top module: `regfile_andor`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, the entry selected by `wr_addr` (1 to 31) holds `wr_data` after that edge, and both read ports return it from the next cycle on.
- R2: The two read ports are combinational and independent: a read port returns the entry named by its own address within the same cycle, and the two ports may name the same entry or different entries at the same time.
- R3: Reset is synchronous and active high. A rising edge with `rst` high clears all 32 entries, so every address reads as zero afterwards.
- R4: After reset, address 0 always reads as zero on both ports, including after one or more writes to address 0.
- R5: A write with `wr_addr` equal to 0 leaves every entry unchanged.
- R6: During the cycle in which an entry is being written, a read of that entry returns its old value. The new value appears only after the clock edge.
- R7: A write changes only the entry it addresses. All other entries keep their values.
- R8: Reset overrides a write that is requested on the same edge: with `rst` and `wr_en` both high, the addressed entry reads as zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write entry index |
| wr_data | input | 32 | Write data |
| rd_a_addr | input | 5 | Read port A entry index |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_addr | input | 5 | Read port B entry index |
| rd_b_data | output | 32 | Read port B data (combinational) |

## Verification
Read results are due in the same cycle as the address, so the bench changes addresses on the falling edge and samples one nanosecond later, well before the next rising edge. A write or a reset takes effect at the rising edge where it is presented, so its effect on the outputs is sampled after the following falling edge. For the read-during-write case, the bench samples in the same half cycle as the write request, which is before the edge, and expects the old value. It then samples again after the edge and expects the new value.

// File: rtl/regfile_andor.sv
module regfile_andor #(
  parameter int ENTRIES = 32,
  parameter int WIDTH   = 32,
  localparam int AW     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_a_addr,
  output logic [WIDTH-1:0] rd_a_data,
  input  logic [AW-1:0]    rd_b_addr,
  output logic [WIDTH-1:0] rd_b_data
);

  logic [WIDTH-1:0]   mem [ENTRIES];
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] sel_a;
  logic [ENTRIES-1:0] sel_b;

  // write decode: slot 0 never gets a strobe
  assign wr_sel[0] = 1'b0;
  for (genvar i = 1; i < ENTRIES; i++) begin : g_wdec
    assign wr_sel[i] = wr_en && (wr_addr == AW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else begin
      for (int i = 1; i < ENTRIES; i++)
        if (wr_sel[i]) mem[i] <= wr_data;
    end
  end

  // read decode: one-hot selects
  for (genvar i = 0; i < ENTRIES; i++) begin : g_rdec
    assign sel_a[i] = (rd_a_addr == AW'(i));
    assign sel_b[i] = (rd_b_addr == AW'(i));
  end

  // AND-OR reduction
  always_comb begin
    rd_a_data = '0;
    rd_b_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      rd_a_data = rd_a_data | (mem[i] & {WIDTH{sel_a[i]}});
      rd_b_data = rd_b_data | (mem[i] & {WIDTH{sel_b[i]}});
    end
  end

  // R1
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=> mem[$past(wr_addr)] == $past(wr_data));

  // R2
  read_a_match_chk: assert property (@(posedge clk) disable iff (rst)
    rd_a_data == mem[rd_a_addr]);

  // R2
  read_b_match_chk: assert property (@(posedge clk) disable iff (rst)
    rd_b_data == mem[rd_b_addr]);

  // R3
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (rd_a_data == '0 && rd_b_data == '0));

  // R4
  zero_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_a_addr == '0) |-> rd_a_data == '0) and ((rd_b_addr == '0) |-> rd_b_data == '0));

  // R5
  zero_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_addr == '0) |=> (rd_a_addr != $past(rd_a_addr) || rd_a_data == $past(rd_a_data)));

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(sel_a) == 1 && $countones(sel_b) == 1 && !wr_sel[0]);

endmodule

// File: tb/regfile_andor_tb.sv
module regfile_andor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_a_addr = '0;
  logic [31:0] rd_a_data;
  logic [4:0]  rd_b_addr = '0;
  logic [31:0] rd_b_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] model [32];

  always #2.5 clk = ~clk;

  regfile_andor dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_both(string req, logic [4:0] a, logic [4:0] b);
    @(negedge clk);
    rd_a_addr = a;
    rd_b_addr = b;
    #1;
    check(req, rd_a_data, model[a]);
    check(req, rd_b_data, model[b]);
  endtask

  task automatic write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a != 0) model[a] = d;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  // R3: all entries zero after reset
  task automatic t_reset();
    for (int i = 0; i < 32; i++) read_both("R3", 5'(i), 5'(31 - i));
  endtask

  // R1 R2 R7: fill distinct patterns, read back on both ports
  task automatic t_fill();
    for (int i = 1; i < 32; i++) write(5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101));
    for (int i = 0; i < 32; i++) read_both("R1", 5'(i), 5'(i));
    for (int i = 0; i < 32; i++) read_both("R2", 5'(i), 5'((i * 7) % 32));
    write(5'd9, 32'hFFFF0000);
    for (int i = 0; i < 32; i++) read_both("R7", 5'(i), 5'(i ^ 9));
  endtask

  // R4 R5: writes to entry 0 have no effect
  task automatic t_zero();
    write(5'd0, 32'hFFFFFFFF);
    write(5'd0, 32'h12345678);
    read_both("R4", 5'd0, 5'd0);
    for (int i = 1; i < 32; i++) read_both("R5", 5'(i), 5'd0);
  endtask

  // R6: read of the entry under write returns old data until the edge
  task automatic t_rdw();
    logic [31:0] old = model[17];
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd17; wr_data = 32'hDEADBEEF;
    rd_a_addr = 5'd17; rd_b_addr = 5'd17;
    #1;
    check("R6", rd_a_data, old);
    check("R6", rd_b_data, old);
    @(negedge clk);
    wr_en = 1'b0;
    model[17] = 32'hDEADBEEF;
    #1;
    check("R6", rd_a_data, 32'hDEADBEEF);
    check("R6", rd_b_data, 32'hDEADBEEF);
  endtask

  // R8: reset wins over a simultaneous write
  task automatic t_rst_vs_wr();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'hCAFEF00D;
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    read_both("R8", 5'd5, 5'd5);
    read_both("R3", 5'd17, 5'd31);
  endtask

  // R1: walking ones on one entry
  task automatic t_walk();
    for (int b = 0; b < 32; b++) begin
      write(5'd31, 32'h1 << b);
      read_both("R1", 5'd31, 5'd30);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill();
    t_zero();
    t_rdw();
    t_walk();
    t_rst_vs_wr();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule